// File: doc/BRIEF.md
# FIFO-Buffered SPI Master with Interrupts

This block is an SPI master that a processor drives over a small word-addressed register bus. Software fills an eight-entry transmit queue and programs the word length (1 to 32 bits), the serial clock rate, the idle gap between words, the target select line and its polarity. It then sets an exchange bit. The block sends the queued words in SPI mode 0, most significant bit first. It stores each word it receives in an eight-entry receive queue. When the transmit queue is empty and the last word has finished, it clears the exchange bit by itself.

One interrupt line reports queue levels and completion, and software picks which conditions raise it. Status events stay set until software writes a one to them. Clearing the enable bit flushes both queues and stops the shifter, and the configuration is kept.

Register word addresses on `bus_addr`: 0 receive data (a read removes the head word), 1 transmit data (a write appends), 2 control, 3 interrupt enable, 4 status, 5 wait states.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, status (address 4) reads 0x1, control reads 0, `irq` is 0, `sclk` is 0 and all four `ss` lines are high.
- R2: Control bits 12:8 hold the word length minus one. Each word is sent MSB first in SPI mode 0: `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge. The received bits are right-aligned in the receive word, and a read of address 0 returns and removes the oldest word.
- R3: Control bits 18:16 hold a rate code r. `sclk` stays high for 2^(r+1) clocks and low for 2^(r+1) clocks, so code 0 divides the system clock by 4. `sclk` is low whenever no select is active.
- R4: Writing 1 to control bit 2 starts an exchange. The bit returns to 0 once the transmit queue is empty and the last word and its gap have finished. At that point status bit 6 (complete) is set.
- R5: Writing 1 to status bit 6 or bit 5 clears that flag. If a clearing write arrives in the same cycle that the flag is being set, the flag stays set.
- R6: Status bit 5 (overflow) is set when a word is received while the receive queue holds 8 words, and that word is discarded.
- R7: Status bit 0 is 1 when the transmit queue holds at most 4 words. Bit 1 is 1 when it holds 8. Bit 2 is 1 when the receive queue is not empty. Bit 3 is 1 when the receive queue holds at least 4 words.
- R8: `irq` is the OR of (status bit 0 AND enable bit 0), (status bit 2 AND enable bit 1), (status bit 3 AND enable bit 2) and (status bit 6 AND enable bit 3), where the enable bits are those of address 3.
- R9: Control bits 25:24 choose which `ss` line is driven. Control bit 4 sets its active level (1 means active high). All other lines stay at the inactive level.
- R10: When control bit 3 is 1, the select goes inactive during the gap after every word. When it is 0, the select stays active from the first word to the last.
- R11: The low 16 bits W at address 5 set a gap of W+1 clocks after every word, including the last one.
- R12: Writing 0 to control bit 0 empties both queues, stops any shift and clears the exchange bit.
- R13: Writing 0 to the exchange bit during a transfer stops it at once. All selects go inactive, `sclk` goes low, no word is stored and the complete flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 4 | Slave select lines |

## Verification
Two writers can touch the complete flag in the same cycle: the shifter sets it at the end of a transfer, and software may be clearing it with a write-one. The bench starts a one-word exchange and holds a write-one to the complete bit on the bus for every cycle up to and including the cycle in which the flag is set. The cycle count follows from the word length, the rate code and the wait setting. Once the write is released, the flag must read 1 and the exchange bit must read 0. The same bench also measures select-active cycles and `sclk` edges on randomly configured transfers. It fills the receive queue past its depth to check overflow.

// File: rtl/spim_pkg.sv
package spim_pkg;
    // register word addresses
    localparam logic [2:0] ADDR_RX   = 3'd0;
    localparam logic [2:0] ADDR_TX   = 3'd1;
    localparam logic [2:0] ADDR_CTRL = 3'd2;
    localparam logic [2:0] ADDR_IEN  = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;
    localparam logic [2:0] ADDR_WAIT = 3'd5;
    // control field positions
    localparam int C_EN   = 0;
    localparam int C_XCH  = 2;
    localparam int C_NEG  = 3;
    localparam int C_POL  = 4;
    localparam int C_LEN  = 8;
    localparam int C_RATE = 16;
    localparam int C_CS   = 24;
    // status bits
    localparam int S_TXHE = 0;
    localparam int S_TXF  = 1;
    localparam int S_RXR  = 2;
    localparam int S_RXHF = 3;
    localparam int S_OVF  = 5;
    localparam int S_TC   = 6;
    // interrupt enable bits
    localparam int I_TXHE = 0;
    localparam int I_RXR  = 1;
    localparam int I_RXHF = 2;
    localparam int I_TC   = 3;

    typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_GAP} eng_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DW    = 32,
    parameter int RATEW = 3,
    parameter int WAITW = 16,
    localparam int LW   = $clog2(DW),
    localparam int DIVW = (1 << RATEW) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             go,
    input  logic             neg,
    input  logic [LW-1:0]    len_m1,
    input  logic [RATEW-1:0] rate,
    input  logic [WAITW-1:0] wait_n,
    input  logic             tx_avail,
    input  logic [DW-1:0]    tx_word,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [DW-1:0]    rx_word,
    output logic             fin,
    output logic             sclk,
    output logic             mosi,
    output logic             sel_on
);
    typedef struct packed {
        eng_state_e       st;
        logic [DIVW-1:0]  div;
        logic [LW-1:0]    bits;
        logic [WAITW-1:0] wcnt;
        logic             sclk;
        logic [DW-1:0]    txsh;
        logic [DW-1:0]    rxsh;
        logic             push;
        logic             fin;
    } eng_t;

    eng_t q, d;
    logic launch;
    logic [DIVW-1:0] half_m1;

    assign half_m1 = DIVW'((DIVW'(1) << (32'(rate) + 1)) - DIVW'(1));

    always_comb begin
        d = q;
        d.push = 1'b0;
        d.fin  = 1'b0;
        launch = 1'b0;
        if (!en || (!go && q.st != ENG_IDLE)) begin
            d.st   = ENG_IDLE;
            d.sclk = 1'b0;
        end else begin
            case (q.st)
                ENG_IDLE: begin
                    if (go && !q.fin) begin
                        if (tx_avail) launch = 1'b1;
                        else          d.fin  = 1'b1;
                    end
                end
                ENG_SHIFT: begin
                    if (q.div == '0) begin
                        d.div = half_m1;
                        if (!q.sclk) begin
                            d.sclk = 1'b1;
                            d.rxsh = {q.rxsh[DW-2:0], miso};
                        end else begin
                            d.sclk = 1'b0;
                            if (q.bits == '0) begin
                                d.st   = ENG_GAP;
                                d.wcnt = wait_n;
                                d.push = 1'b1;
                            end else begin
                                d.bits = q.bits - 1'b1;
                                d.txsh = q.txsh << 1;
                            end
                        end
                    end else begin
                        d.div = q.div - 1'b1;
                    end
                end
                ENG_GAP: begin
                    if (q.wcnt == '0) begin
                        if (tx_avail) begin
                            launch = 1'b1;
                        end else begin
                            d.st  = ENG_IDLE;
                            d.fin = 1'b1;
                        end
                    end else begin
                        d.wcnt = q.wcnt - 1'b1;
                    end
                end
                default: d.st = ENG_IDLE;
            endcase
        end
        if (launch) begin
            d.st   = ENG_SHIFT;
            d.div  = half_m1;
            d.bits = len_m1;
            d.sclk = 1'b0;
            d.txsh = tx_word << (DW - 1 - int'(len_m1));
            d.rxsh = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_pop  = launch;
    assign rx_push = q.push;
    assign rx_word = q.rxsh;
    assign fin     = q.fin;
    assign sclk    = q.sclk;
    assign mosi    = q.txsh[DW-1];
    assign sel_on  = (q.st == ENG_SHIFT) || (q.st == ENG_GAP && !neg);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int NSEL  = 4,
    parameter int RATEW = 3,
    parameter int WAITW = 16,
    localparam int CSW  = (NSEL > 1) ? $clog2(NSEL) : 1,
    localparam int LW   = $clog2(DW),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [2:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NSEL-1:0] ss
);
    typedef struct packed {
        logic             en;
        logic             xch;
        logic             neg;
        logic             pol;
        logic [CSW-1:0]   cs;
        logic [RATEW-1:0] rate;
        logic [LW-1:0]    len;
        logic [3:0]       ien;
        logic [WAITW-1:0] waitn;
        logic             tc;
        logic             ovf;
    } regs_t;

    regs_t q, d;
    logic wr, rd;
    logic tx_push, tx_pop, rx_pop, rx_full, tx_full;
    logic eng_push, eng_fin, sel_on;
    logic [DW-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [31:0] stat, ctl;
    logic [3:0]  cond;
    logic xch_r, tc_r, ovf_r, pol_r;
    logic [3:0] ien_r;

    assign wr      = bus_sel && bus_wr;
    assign rd      = bus_sel && !bus_wr;
    assign tx_full = (tx_cnt == CW'(DEPTH));
    assign rx_full = (rx_cnt == CW'(DEPTH));
    assign tx_push = wr && (bus_addr == ADDR_TX) && q.en;
    assign rx_pop  = rd && (bus_addr == ADDR_RX);

    spim_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(!q.en), .push(tx_push),
        .wdata(bus_wdata[DW-1:0]), .pop(tx_pop), .rdata(tx_head), .count(tx_cnt)
    );

    spim_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(!q.en), .push(eng_push && !rx_full),
        .wdata(rx_word), .pop(rx_pop), .rdata(rx_head), .count(rx_cnt)
    );

    spim_engine #(.DW(DW), .RATEW(RATEW), .WAITW(WAITW)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(q.en), .go(q.xch), .neg(q.neg),
        .len_m1(q.len), .rate(q.rate), .wait_n(q.waitn),
        .tx_avail(tx_cnt != '0), .tx_word(tx_head), .miso(miso),
        .tx_pop(tx_pop), .rx_push(eng_push), .rx_word(rx_word), .fin(eng_fin),
        .sclk(sclk), .mosi(mosi), .sel_on(sel_on)
    );

    always_comb begin
        d = q;
        if (wr) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    d.en   = bus_wdata[C_EN];
                    d.xch  = bus_wdata[C_XCH];
                    d.neg  = bus_wdata[C_NEG];
                    d.pol  = bus_wdata[C_POL];
                    d.len  = bus_wdata[C_LEN +: LW];
                    d.rate = bus_wdata[C_RATE +: RATEW];
                    d.cs   = bus_wdata[C_CS +: CSW];
                end
                ADDR_IEN:  d.ien   = bus_wdata[3:0];
                ADDR_WAIT: d.waitn = bus_wdata[WAITW-1:0];
                ADDR_STAT: begin
                    if (bus_wdata[S_TC])  d.tc  = 1'b0;
                    if (bus_wdata[S_OVF]) d.ovf = 1'b0;
                end
                default: ;
            endcase
        end
        // hardware events win over software clears
        if (eng_fin) begin
            d.tc  = 1'b1;
            d.xch = 1'b0;
        end
        if (eng_push && rx_full) d.ovf = 1'b1;
        if (!d.en) d.xch = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat         = '0;
        stat[S_TXHE] = (tx_cnt <= CW'(DEPTH / 2));
        stat[S_TXF]  = tx_full;
        stat[S_RXR]  = (rx_cnt != '0);
        stat[S_RXHF] = (rx_cnt >= CW'(DEPTH / 2));
        stat[S_OVF]  = q.ovf;
        stat[S_TC]   = q.tc;
        ctl               = '0;
        ctl[C_EN]         = q.en;
        ctl[C_XCH]        = q.xch;
        ctl[C_NEG]        = q.neg;
        ctl[C_POL]        = q.pol;
        ctl[C_LEN +: LW]  = q.len;
        ctl[C_RATE +: RATEW] = q.rate;
        ctl[C_CS +: CSW]  = q.cs;
        case (bus_addr)
            ADDR_RX:   bus_rdata = 32'(rx_head);
            ADDR_CTRL: bus_rdata = ctl;
            ADDR_IEN:  bus_rdata = 32'(q.ien);
            ADDR_STAT: bus_rdata = stat;
            ADDR_WAIT: bus_rdata = 32'(q.waitn);
            default:   bus_rdata = '0;
        endcase
    end

    assign cond[I_TXHE] = stat[S_TXHE];
    assign cond[I_RXR]  = stat[S_RXR];
    assign cond[I_RXHF] = stat[S_RXHF];
    assign cond[I_TC]   = stat[S_TC];
    assign irq = |(cond & q.ien);

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign ss[i] = (sel_on && q.cs == CSW'(i)) ? q.pol : ~q.pol;
    end

    assign xch_r = q.xch;
    assign tc_r  = q.tc;
    assign ovf_r = q.ovf;
    assign pol_r = q.pol;
    assign ien_r = q.ien;
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
    parameter int NSEL  = 4,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSEL-1:0] ss,
    input logic            pol,
    input logic            sclk,
    input logic            mosi,
    input logic            xch,
    input logic            tc,
    input logic            ovf,
    input logic [CW-1:0]   rx_cnt,
    input logic            irq,
    input logic [3:0]      ien
);
    logic [NSEL-1:0] act;
    assign act = pol ? ss : ~ss;

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> !sclk);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4
    tc_with_xch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc) |-> $fell(xch));

    // R6
    ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(rx_cnt) == CW'(DEPTH)));

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien != 4'd0));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.NSEL(NSEL), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ss(ss), .pol(pol_r), .sclk(sclk), .mosi(mosi),
    .xch(xch_r), .tc(tc_r), .ovf(ovf_r), .rx_cnt(rx_cnt), .irq(irq), .ien(ien_r)
);

// File: tb/spi_fifo_master_test.sv
module spi_fifo_master_test;
    import spim_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, sclk, mosi, miso;
    logic [3:0] ss;

    int checks = 0, errs = 0;
    int act_cnt = 0, starts = 0, rises = 0, wrong = 0;
    bit prev_act = 0, prev_sclk = 0;
    bit cur_pol = 0;
    int cur_cs = 0;
    logic [31:0] txw [16];

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign miso = ~mosi;

    spi_fifo_master uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss(ss)
    );

    always @(negedge clk) begin
        logic [3:0] act;
        act = cur_pol ? ss : ~ss;
        if (act[cur_cs]) act_cnt++;
        if (act[cur_cs] && !prev_act) starts++;
        prev_act = act[cur_cs];
        if ((act & ~(4'b1 << cur_cs)) != 4'b0) wrong = 1;
        if (sclk && !prev_sclk) rises++;
        prev_sclk = sclk;
    end

    function automatic logic [31:0] mk_ctrl(bit en, bit xch, bit neg, bit pol,
                                            int nbits, int rate, int cs);
        logic [31:0] v = '0;
        v[C_EN] = en; v[C_XCH] = xch; v[C_NEG] = neg; v[C_POL] = pol;
        v[C_LEN +: 5]  = 5'(nbits - 1);
        v[C_RATE +: 3] = 3'(rate);
        v[C_CS +: 2]   = 2'(cs);
        return v;
    endfunction

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 40000; i++) begin
            bus_read(ADDR_CTRL, v);
            if (!v[C_XCH]) return;
        end
        chk_eq("R4 exchange never ended", 1, 0);
    endtask

    task automatic clear_counts();
        @(negedge clk);
        #1 act_cnt = 0; starts = 0; rises = 0; wrong = 0;
    endtask

    task automatic run_xfer(input int n, input int nb, input int rate, input int w,
                            input bit neg, input bit pol, input int cs);
        logic [31:0] v;
        logic [63:0] mask;
        int half, per_word;
        mask = (64'd1 << nb) - 64'd1;
        bus_write(ADDR_CTRL, mk_ctrl(1, 0, neg, pol, nb, rate, cs));
        cur_pol = pol; cur_cs = cs;
        bus_write(ADDR_WAIT, 32'(w));
        for (int i = 0; i < n; i++) begin
            txw[i] = $urandom();
            bus_write(ADDR_TX, txw[i]);
        end
        clear_counts();
        bus_write(ADDR_CTRL, mk_ctrl(1, 1, neg, pol, nb, rate, cs));
        wait_idle();
        half = 1 << (rate + 1);
        per_word = 2 * nb * half + (neg ? 0 : w + 1);
        chk_eq("R3 R11 select-active cycles", 64'(act_cnt), 64'(n * per_word));
        chk_eq("R10 select activations", 64'(starts), neg ? 64'(n) : 64'd1);
        chk_eq("R2 sclk rising edges", 64'(rises), 64'(n * nb));
        chk_eq("R9 other selects idle", 64'(wrong), 0);
        chk_eq("R9 idle level", 64'(ss), pol ? 64'h0 : 64'hF);
        bus_read(ADDR_STAT, v);
        chk_eq("R4 complete flag", 64'(v[S_TC]), 1);
        for (int i = 0; i < n; i++) begin
            bus_read(ADDR_RX, v);
            chk_eq("R2 received word", 64'(v), 64'(~txw[i]) & mask);
        end
        bus_write(ADDR_STAT, 32'h1 << S_TC);
        bus_read(ADDR_STAT, v);
        chk_eq("R5 complete cleared", 64'(v[S_TC]), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int seed;
        seed = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        bus_read(ADDR_STAT, v); chk_eq("R1 status", 64'(v), 64'h1);
        bus_read(ADDR_CTRL, v); chk_eq("R1 control", 64'(v), 0);
        chk_eq("R1 irq", 64'(irq), 0);
        chk_eq("R1 selects", 64'(ss), 64'hF);
        chk_eq("R1 sclk", 64'(sclk), 0);

        // directed corner widths, then random configurations
        run_xfer(2, 32, 0, 0, 0, 0, 0);
        run_xfer(3, 1, 1, 2, 1, 1, 3);
        for (int t = 0; t < 6; t++) begin
            run_xfer(int'($urandom_range(1, 8)), int'($urandom_range(1, 32)),
                     int'($urandom_range(0, 2)), int'($urandom_range(0, 7)),
                     bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                     int'($urandom_range(0, 3)));
        end

        // R5 collision: clearing write held through the set cycle
        bus_write(ADDR_CTRL, mk_ctrl(1, 0, 0, 0, 8, 0, 1));
        cur_pol = 0; cur_cs = 1;
        bus_write(ADDR_WAIT, 0);
        bus_write(ADDR_TX, 32'hA5);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = ADDR_CTRL;
        bus_wdata = mk_ctrl(1, 1, 0, 0, 8, 0, 1);
        @(negedge clk);
        bus_addr = ADDR_STAT; bus_wdata = 32'h1 << S_TC;
        repeat (35) @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        bus_read(ADDR_STAT, v); chk_eq("R5 set wins over clear", 64'(v[S_TC]), 1);
        bus_read(ADDR_CTRL, v); chk_eq("R4 exchange bit cleared", 64'(v[C_XCH]), 0);
        bus_read(ADDR_RX, v);   chk_eq("R2 collision word", 64'(v), 64'h5A);
        bus_write(ADDR_STAT, 32'h1 << S_TC);

        // R6 overflow
        for (int i = 0; i < 10; i++) txw[i] = $urandom();
        for (int i = 0; i < 8; i++) bus_write(ADDR_TX, txw[i]);
        bus_write(ADDR_CTRL, mk_ctrl(1, 1, 0, 0, 8, 0, 1));
        wait_idle();
        bus_read(ADDR_STAT, v);
        chk_eq("R6 no overflow at exactly full", 64'(v[S_OVF]), 0);
        chk_eq("R7 rx half full", 64'(v[S_RXHF]), 1);
        for (int i = 8; i < 10; i++) bus_write(ADDR_TX, txw[i]);
        bus_write(ADDR_CTRL, mk_ctrl(1, 1, 0, 0, 8, 0, 1));
        wait_idle();
        bus_read(ADDR_STAT, v);
        chk_eq("R6 overflow set", 64'(v[S_OVF]), 1);
        // R8 interrupt selection with RX full, TX empty, complete set
        bus_write(ADDR_IEN, 32'h0); #1 chk_eq("R8 irq all masked", 64'(irq), 0);
        bus_write(ADDR_IEN, 32'h2); #1 chk_eq("R8 irq rx ready", 64'(irq), 1);
        bus_write(ADDR_IEN, 32'h4); #1 chk_eq("R8 irq rx half full", 64'(irq), 1);
        bus_write(ADDR_IEN, 32'h1); #1 chk_eq("R8 irq tx half empty", 64'(irq), 1);
        for (int i = 0; i < 8; i++) begin
            bus_read(ADDR_RX, v);
            chk_eq("R6 kept word", 64'(v), 64'(~txw[i] & 32'hFF));
        end
        bus_read(ADDR_STAT, v);
        chk_eq("R6 extra words discarded", 64'(v[S_RXR]), 0);
        bus_write(ADDR_IEN, 32'hE); #1 chk_eq("R8 irq complete", 64'(irq), 1);
        bus_write(ADDR_STAT, (32'h1 << S_TC) | (32'h1 << S_OVF));
        #1 chk_eq("R8 irq none pending", 64'(irq), 0);
        bus_read(ADDR_STAT, v); chk_eq("R5 overflow cleared", 64'(v[S_OVF]), 0);
        bus_write(ADDR_IEN, 32'h0);

        // R7 TX levels, then R12 enable clear
        for (int i = 0; i < 4; i++) bus_write(ADDR_TX, 32'h11);
        bus_read(ADDR_STAT, v);
        chk_eq("R7 tx four half empty", 64'(v[1:0]), 64'h1);
        bus_write(ADDR_TX, 32'h11);
        bus_read(ADDR_STAT, v);
        chk_eq("R7 tx five", 64'(v[1:0]), 64'h0);
        for (int i = 0; i < 3; i++) bus_write(ADDR_TX, 32'h11);
        bus_read(ADDR_STAT, v);
        chk_eq("R7 tx full", 64'(v[1:0]), 64'h2);
        bus_write(ADDR_CTRL, mk_ctrl(0, 1, 0, 0, 8, 0, 1));
        bus_read(ADDR_CTRL, v); chk_eq("R12 exchange held off", 64'(v[C_XCH]), 0);
        bus_write(ADDR_CTRL, mk_ctrl(1, 0, 0, 0, 8, 0, 1));
        bus_read(ADDR_STAT, v); chk_eq("R12 queues emptied", 64'(v), 64'h1);
        clear_counts();
        bus_write(ADDR_CTRL, mk_ctrl(1, 1, 0, 0, 8, 0, 1));
        wait_idle();
        chk_eq("R12 nothing left to send", 64'(rises), 0);
        bus_write(ADDR_STAT, 32'h1 << S_TC);

        // R13 abort mid-word
        bus_write(ADDR_CTRL, mk_ctrl(1, 0, 0, 1, 32, 2, 2));
        cur_pol = 1; cur_cs = 2;
        bus_write(ADDR_TX, 32'hDEADBEEF);
        bus_write(ADDR_TX, 32'h12345678);
        bus_write(ADDR_CTRL, mk_ctrl(1, 1, 0, 1, 32, 2, 2));
        repeat (40) @(negedge clk);
        bus_write(ADDR_CTRL, mk_ctrl(1, 0, 0, 1, 32, 2, 2));
        repeat (2) @(negedge clk);
        chk_eq("R13 selects idle", 64'(ss), 64'h0);
        chk_eq("R13 sclk low", 64'(sclk), 0);
        bus_read(ADDR_STAT, v);
        chk_eq("R13 no complete, no word", 64'(v[S_TC] | v[S_RXR]), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule